// File: doc/BRIEF.md
# Synthesizer Divider Serial Loader

This block programs a dual-modulus frequency synthesizer over a three-wire serial link made of a clock, a data line and a load strobe. A host gives it a channel number, from 1 to 46, and a one-cycle start pulse. The block converts the channel into a total divide value on a 12.5 kHz grid, starting at 32598. It splits that value by the prescaler modulus of 64 into a programmable count (the quotient) and a swallow count (the remainder).

The block then shifts out two 19-bit words, most significant bit first. The first word carries the reference-counter value, which is fixed at 1700, together with four configuration bits. The second word carries the two counts. The last bit of each word tells the synthesizer which latch receives it. Every serial phase lasts a parameterised number of system clocks, so the synthesizer's setup, hold, pulse-width and spacing minimums can be met at any system clock rate. A done pulse marks the end of a transfer. A channel number out of range raises an error flag and nothing is sent.

Top module: `synth_word_loader`

## Requirements
- R1: While reset is asserted and after it is released, the serial clock, the data line, the load strobe, done and err are all low.
- R2: For channel c, the divide value is n = 32597 + c. The programmable count is n / 64 (integer part) and the swallow count is n mod 64, carried in a 7-bit field. For example, c = 27 gives counts 509 and 48, and c = 43 gives 510 and 0.
- R3: The first word, from bit 18 down to bit 0, is: charge-pump select, lock-output select, phase polarity, prescaler select, the reference count 1700 in 14 bits, then a 1.
- R4: The second word, from bit 18 down to bit 0, is: the 11-bit programmable count, the 7-bit swallow count, then a 0.
- R5: Each word is presented as exactly 19 rising edges of the serial clock, with the data bit valid at each rising edge. The load strobe stays low while bits are shifted and pulses high once after the 19th bit. The first word goes out before the second.
- R6: Phase timing in system clocks: the data line is stable for HALF_CYC cycles before and through each high phase. The clock is high for HALF_CYC cycles and low for at least HALF_CYC cycles. The clock stays low for LEAD_CYC + HALF_CYC cycles before the first rising edge of each word. It stays low for LEAD_CYC cycles between the last high phase and the strobe. The strobe is high for LE_CYC cycles. There are LEAD_CYC idle cycles after the first strobe.
- R7: done is high for exactly one cycle, in the cycle right after the second strobe pulse ends.
- R8: A start pulse that arrives during a transfer is ignored, and so are changes to the channel or configuration inputs during a transfer. The channel and configuration values are captured on the accepted start. A start is accepted when the block is idle or in its done cycle.
- R9: An accepted start with a channel of 0 or above 46 sets err in the next cycle and produces no serial activity. err holds until the next accepted start, which clears it if that start's channel is valid.
- R10: Between transfers the serial clock, the data line and the load strobe stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to load a channel |
| chan_idx | input | 6 | Channel number, valid from 1 to 46 |
| cfg_cp | input | 1 | Charge-pump current select bit |
| cfg_ldsel | input | 1 | Lock-output function select bit |
| cfg_phase | input | 1 | Phase comparator polarity bit |
| cfg_presc | input | 1 | Prescaler modulus select bit |
| ser_clk | output | 1 | Serial clock to the synthesizer |
| ser_data | output | 1 | Serial data to the synthesizer |
| ser_le | output | 1 | Load strobe to the synthesizer |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Last accepted channel was out of range |

## Verification
A wrong phase counter or bit index in this block changes the length of some phase on the serial pins. The cycle-accurate comparison flags that within one system clock of the first phase that runs long or short. A wrong division split or a wrong field order gives no timing error at all. It shows up only in the words the bench rebuilds from the serial clock's rising edges, and it is caught at the done pulse, about 270 cycles after the start. A fault in the busy gating shows up at the first ignored start, as a transfer that begins early or again.

// File: rtl/synth_word_loader.sv
module synth_word_loader #(
  parameter int BASE_DIV = 32598,
  parameter int NUM_CH   = 46,
  parameter int REF_DIV  = 1700,
  parameter int LEAD_CYC = 10,
  parameter int HALF_CYC = 3,
  parameter int LE_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [5:0] chan_idx,
  input  logic       cfg_cp,
  input  logic       cfg_ldsel,
  input  logic       cfg_phase,
  input  logic       cfg_presc,
  output logic       ser_clk,
  output logic       ser_data,
  output logic       ser_le,
  output logic       done,
  output logic       err
);

  localparam int NW = $clog2(BASE_DIV + NUM_CH + 1);
  localparam int CW = $clog2(LEAD_CYC + HALF_CYC + LE_CYC + 1);
  localparam int WL = 19;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LOW, S_HIGH, S_TAIL, S_PULSE, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [4:0]    bitn;
  logic          second;
  logic [WL-1:0] ref_w, prog_w;

  logic [NW-1:0] div_n;
  logic [10:0]   prog_cnt;
  logic [6:0]    swal_cnt;
  logic          idx_ok, can_take;

  assign div_n    = NW'(BASE_DIV - 1) + NW'(chan_idx);
  assign prog_cnt = 11'(div_n >> 6);
  assign swal_cnt = {1'b0, div_n[5:0]};
  assign idx_ok   = (chan_idx != 6'd0) && (chan_idx <= 6'(NUM_CH));
  assign can_take = (st == S_IDLE) || (st == S_DONE);

  assign ser_clk  = (st == S_HIGH);
  assign ser_le   = (st == S_PULSE);
  assign done     = (st == S_DONE);
  assign ser_data = (st == S_LEAD || st == S_LOW || st == S_HIGH) ?
                    (second ? prog_w[bitn] : ref_w[bitn]) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      second <= 1'b0;
      ref_w  <= '0;
      prog_w <= '0;
      err    <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          st <= S_IDLE;
          if (start) begin
            err <= !idx_ok;
            if (idx_ok) begin
              st     <= S_LEAD;
              cnt    <= CW'(LEAD_CYC - 1);
              bitn   <= 5'(WL - 1);
              second <= 1'b0;
              ref_w  <= {cfg_cp, cfg_ldsel, cfg_phase, cfg_presc, 14'(REF_DIV), 1'b1};
              prog_w <= {prog_cnt, swal_cnt, 1'b0};
            end
          end
        end
        S_LEAD: begin
          if (cnt == 0) begin st <= S_LOW; cnt <= CW'(HALF_CYC - 1); end
          else cnt <= cnt - 1'b1;
        end
        S_LOW: begin
          if (cnt == 0) begin st <= S_HIGH; cnt <= CW'(HALF_CYC - 1); end
          else cnt <= cnt - 1'b1;
        end
        S_HIGH: begin
          if (cnt == 0) begin
            if (bitn == 0) begin
              st  <= S_TAIL;
              cnt <= CW'(LEAD_CYC - 1);
            end else begin
              st   <= S_LOW;
              cnt  <= CW'(HALF_CYC - 1);
              bitn <= bitn - 1'b1;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_TAIL: begin
          if (cnt == 0) begin st <= S_PULSE; cnt <= CW'(LE_CYC - 1); end
          else cnt <= cnt - 1'b1;
        end
        S_PULSE: begin
          if (cnt == 0) begin
            if (!second) begin
              second <= 1'b1;
              bitn   <= 5'(WL - 1);
              st     <= S_LEAD;
              cnt    <= CW'(LEAD_CYC - 1);
            end else st <= S_DONE;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5: strobe never overlaps a clock high phase or follows one directly
  p_le_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |-> (!ser_clk && !$past(ser_clk)));

  // R6: data already settled when the clock rises
  p_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_data));

  // R6: data held through the high phase
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  // R7: done lasts one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: bad channel flags an error and starts nothing
  p_bad_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && can_take && !idx_ok) |=> (err && !ser_clk && !ser_le && !ser_data));

endmodule

// File: tb/tb_synth_word_loader.sv
module tb_synth_word_loader;
  localparam int CLK_PERIOD = 10;
  localparam int LEAD = 10, HALF = 3, LEP = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [5:0] chan_idx = 6'd0;
  logic cfg_cp = 1'b0, cfg_ldsel = 1'b0, cfg_phase = 1'b1, cfg_presc = 1'b0;
  logic ser_clk, ser_data, ser_le, done, err;

  synth_word_loader #(.LEAD_CYC(LEAD), .HALF_CYC(HALF), .LE_CYC(LEP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_idx(chan_idx),
    .cfg_cp(cfg_cp), .cfg_ldsel(cfg_ldsel), .cfg_phase(cfg_phase), .cfg_presc(cfg_presc),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le), .done(done), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  logic [3:0] q[$];
  logic [3:0] exp_v = 4'b0;
  logic exp_err = 1'b0;
  logic [18:0] exp_ref = '0, exp_prog = '0;

  task automatic push_word(input logic [18:0] w);
    for (int i = 0; i < LEAD; i++) q.push_back({1'b0, w[18], 2'b00});
    for (int b = 18; b >= 0; b--) begin
      for (int i = 0; i < HALF; i++) q.push_back({1'b0, w[b], 2'b00});
      for (int i = 0; i < HALF; i++) q.push_back({1'b1, w[b], 2'b00});
    end
    for (int i = 0; i < LEAD; i++) q.push_back(4'b0000);
    for (int i = 0; i < LEP; i++)  q.push_back(4'b0010);
  endtask

  // reference model: {clk, data, le, done}
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); exp_v = 4'b0; exp_err = 1'b0;
    end else begin
      if (q.size() == 0 && start) begin
        if (chan_idx >= 1 && chan_idx <= 46) begin
          int n, pn, sw;
          n  = 32597 + int'(chan_idx);
          pn = n / 64;
          sw = n % 64;
          exp_ref  = {cfg_cp, cfg_ldsel, cfg_phase, cfg_presc, 14'd1700, 1'b1};
          exp_prog = {11'(pn), 7'(sw), 1'b0};
          exp_err  = 1'b0;
          push_word(exp_ref);
          push_word(exp_prog);
          q.push_back(4'b0001);
        end else exp_err = 1'b1;
      end
      if (q.size() != 0) exp_v = q.pop_front();
      else exp_v = 4'b0;
    end
  end

  // words rebuilt from the serial pins
  logic [18:0] sh = '0, got_ref = '0, got_prog = '0;
  always @(posedge ser_clk) sh = {sh[17:0], ser_data};
  always @(posedge ser_le) if (sh[0]) got_ref = sh; else got_prog = sh;

  always @(negedge clk) begin
    logic [4:0] act;
    act = {ser_clk, ser_data, ser_le, done, err};
    n_cmp++;
    if (act !== {exp_v, exp_err}) begin
      n_bad++;
      $display("FAIL %s: pins clk/data/le/done/err actual %b expected %b at %0t",
               tag, act, {exp_v, exp_err}, $time);
    end
    if (done) begin
      n_cmp++;
      if (got_ref !== exp_ref) begin
        n_bad++;
        $display("FAIL R3 reference word actual %h expected %h", got_ref, exp_ref);
      end
      n_cmp++;
      if (got_prog !== exp_prog) begin
        n_bad++;
        $display("FAIL R2/R4 counter word actual %h expected %h", got_prog, exp_prog);
      end
    end
  end

  task automatic go(input int idx);
    @(negedge clk); chan_idx = 6'(idx); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic settle(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    tag = "R1"; settle(4);
    rst_n = 1'b1; settle(4);

    tag = "R2 R5 R6 R7"; go(27); settle(290);
    tag = "R8";
    go(12);
    settle(40);
    chan_idx = 6'd3; cfg_cp = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    settle(250);

    tag = "R2"; cfg_cp = 1'b0; go(1);  settle(290);
    go(46); settle(290);
    go(43); settle(290);
    go(42); settle(290);

    tag = "R3"; cfg_cp = 1'b1; cfg_ldsel = 1'b1; cfg_phase = 1'b0; cfg_presc = 1'b1;
    go(20); settle(290);
    cfg_cp = 1'b0; cfg_ldsel = 1'b0; cfg_phase = 1'b1; cfg_presc = 1'b0;

    tag = "R9 R10"; go(0); settle(20);
    go(47); settle(20);
    go(63); settle(20);
    tag = "R9"; go(9); settle(290);

    tag = "R4 R8"; chan_idx = 6'd33; start = 1'b1; settle(300);
    chan_idx = 6'd35; settle(200); start = 1'b0; settle(300);

    tag = "R1"; rst_n = 1'b0; settle(3); rst_n = 1'b1; settle(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule